// File: doc/BRIEF.md
# Transmit-Enable Gated Settings Stage

This block sits between a serial configuration receiver and the control pins of a variable-gain line amplifier. It keeps two copies of the gain and output-current codes: a staged copy, which every write to the settings register replaces, and an active copy, which drives the amplifier. Whether a new setting reaches the active copy at once or waits depends on the transmit-enable level.

When transmit is enabled, the end of the write frame (chip select returning high) copies the staged codes into the active outputs. When transmit is disabled, writes are still accepted, but they stay staged until transmit-enable next rises. Each rising edge of transmit-enable reloads the active outputs from the staged copy, so the last programmed setting comes back even when nothing new was written. A soft-reset pulse returns both copies to full gain and full current. Gain codes below the lowest distinct attenuation step are clamped on the active output.

Top module: `txen_settings_stage`

## Requirements
- R1: A write word carries the gain code in bits 5..0 and the current code in bits 7..6; both fields are taken from the same word.
- R2: With synchronised transmit-enable high, the staged codes appear on `gain_act`/`cur_act` at the clock edge where a low-to-high change of `cs_n` is first seen.
- R3: With synchronised transmit-enable low, the end of a frame leaves `gain_act` and `cur_act` unchanged, and the write is still accepted into the staged copy.
- R4: On a rising edge of synchronised transmit-enable, the active outputs load the staged codes on the same clock edge where `amp_en` goes high, and not before.
- R5: A rising edge of transmit-enable with no write since the previous enable restores the last programmed codes.
- R6: An active gain code is never below 5: any staged code 0..5 appears as 5; codes 6..63 pass unchanged.
- R7: A `soft_rst` pulse sets both staged and active copies to gain 63 and current 3 on the next clock edge, and a later enable keeps those values.
- R8: After `rst_n`, `gain_act` is 63, `cur_act` is 3 and `amp_en` is 0.
- R9: `amp_en` follows `tx_en_in` through a two-flop synchroniser plus one register: it changes on the third clock edge after the input changes.
- R10: Gain and current codes change only on a load or soft-reset edge, and always on the same edge.
- R11: A write strobe while `cs_n` is still low does not change the active outputs, even with transmit enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe: `cfg_wdata` is a new settings word |
| cfg_wdata | input | 8 | Settings word: current in [7:6], gain in [5:0] |
| cs_n | input | 1 | Chip select from the receiver, already in the clock domain; rising edge ends a frame |
| tx_en_in | input | 1 | Asynchronous transmit-enable level |
| soft_rst | input | 1 | One-cycle pulse returning all codes to defaults |
| gain_act | output | 6 | Active gain code |
| cur_act | output | 2 | Active output-current code |
| amp_en | output | 1 | Amplifier enable, synchronised transmit-enable |

## Verification
The bench builds the block with its default parameters: a 6-bit gain code with a floor of 5, a 2-bit current code with default 3, and a two-stage synchroniser. The gain width makes the whole clamp region 0..5, the floor value itself, and the full-scale default reachable with a handful of words. The short synchroniser puts the enable latency at three edges, so the bench can check the cycle before and the cycle of the reload, and test frame ends with transmit-enable on each side of that window.

// File: rtl/txs_pkg.sv
package txs_pkg;
   localparam int TXS_GAIN_W     = 6;
   localparam int TXS_CUR_W      = 2;
   localparam int TXS_GAIN_FLOOR = 5;
   localparam int TXS_CUR_DEF    = 3;
   localparam int TXS_SYNC_N     = 2;
endpackage

// File: rtl/txs_sync.sv
module txs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   initial begin
      assert (STAGES >= 2) else $error("txs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_flop
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/txs_stage.sv
module txs_stage #(
   parameter int GAIN_W  = 6,
   parameter int CUR_W   = 2,
   parameter int CUR_DEF = 3,
   localparam int WORD_W = GAIN_W + CUR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [GAIN_W-1:0] nxt_gain,
   output logic [CUR_W-1:0]  nxt_cur
);
   logic [GAIN_W-1:0] stg_gain;
   logic [CUR_W-1:0]  stg_cur;

   // R1: current in the upper field, gain in the lower field
   always_comb begin
      if (wr) begin
         nxt_gain = wdata[GAIN_W-1:0];
         nxt_cur  = wdata[WORD_W-1:GAIN_W];
      end else begin
         nxt_gain = stg_gain;
         nxt_cur  = stg_cur;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_gain <= '1;
         stg_cur  <= CUR_W'(CUR_DEF);
      end else if (soft_rst) begin
         stg_gain <= '1;
         stg_cur  <= CUR_W'(CUR_DEF);
      end else begin
         stg_gain <= nxt_gain;
         stg_cur  <= nxt_cur;
      end
   end

   p_wr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !soft_rst) |=> (stg_cur == $past(wdata[WORD_W-1:GAIN_W])));
endmodule

// File: rtl/txs_active.sv
module txs_active #(
   parameter int GAIN_W     = 6,
   parameter int CUR_W      = 2,
   parameter int GAIN_FLOOR = 5,
   parameter int CUR_DEF    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              load,
   input  logic [GAIN_W-1:0] ld_gain,
   input  logic [CUR_W-1:0]  ld_cur,
   input  logic              tx_lvl,
   output logic [GAIN_W-1:0] gain_act,
   output logic [CUR_W-1:0]  cur_act,
   output logic              amp_en
);
   localparam logic [GAIN_W-1:0] FLOOR_C = GAIN_W'(GAIN_FLOOR);

   logic [GAIN_W-1:0] gain_clamped;

   generate
      if (GAIN_FLOOR > 0) begin : g_clamp
         assign gain_clamped = (ld_gain < FLOOR_C) ? FLOOR_C : ld_gain;
      end else begin : g_pass
         assign gain_clamped = ld_gain;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_act <= '1;
         cur_act  <= CUR_W'(CUR_DEF);
         amp_en   <= 1'b0;
      end else begin
         amp_en <= tx_lvl;
         if (soft_rst) begin
            gain_act <= '1;
            cur_act  <= CUR_W'(CUR_DEF);
         end else if (load) begin
            gain_act <= gain_clamped;
            cur_act  <= ld_cur;
         end
      end
   end

   p_gain_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gain_act >= FLOOR_C);

   p_joint_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !soft_rst) |=> ($stable(gain_act) && $stable(cur_act)));
endmodule

// File: rtl/txen_settings_stage.sv
module txen_settings_stage #(
   parameter int GAIN_W     = txs_pkg::TXS_GAIN_W,
   parameter int CUR_W      = txs_pkg::TXS_CUR_W,
   parameter int GAIN_FLOOR = txs_pkg::TXS_GAIN_FLOOR,
   parameter int CUR_DEF    = txs_pkg::TXS_CUR_DEF,
   parameter int SYNC_N     = txs_pkg::TXS_SYNC_N,
   localparam int WORD_W    = GAIN_W + CUR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              cs_n,
   input  logic              tx_en_in,
   input  logic              soft_rst,
   output logic [GAIN_W-1:0] gain_act,
   output logic [CUR_W-1:0]  cur_act,
   output logic              amp_en
);
   initial begin
      assert (GAIN_W >= 1 && CUR_W >= 1) else $error("field widths must be positive");
      assert (GAIN_FLOOR < (1 << GAIN_W)) else $error("GAIN_FLOOR exceeds gain range");
      assert (CUR_DEF < (1 << CUR_W)) else $error("CUR_DEF exceeds current range");
   end

   logic tx_s, tx_d, tx_rise;
   logic cs_q, cs_rise;
   logic load;
   logic [GAIN_W-1:0] nxt_gain;
   logic [CUR_W-1:0]  nxt_cur;

   txs_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(tx_en_in), .q_sync(tx_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_d <= 1'b0;
         cs_q <= 1'b1;
      end else begin
         tx_d <= tx_s;
         cs_q <= cs_n;
      end
   end

   assign tx_rise = tx_s & ~tx_d;
   assign cs_rise = cs_n & ~cs_q;
   assign load    = (cs_rise & tx_s) | tx_rise;

   txs_stage #(.GAIN_W(GAIN_W), .CUR_W(CUR_W), .CUR_DEF(CUR_DEF)) u_stage (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr(cfg_wr),
      .wdata(cfg_wdata), .nxt_gain(nxt_gain), .nxt_cur(nxt_cur));

   txs_active #(.GAIN_W(GAIN_W), .CUR_W(CUR_W), .GAIN_FLOOR(GAIN_FLOOR),
                .CUR_DEF(CUR_DEF)) u_active (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .load(load),
      .ld_gain(nxt_gain), .ld_cur(nxt_cur), .tx_lvl(tx_s),
      .gain_act(gain_act), .cur_act(cur_act), .amp_en(amp_en));

   p_frame_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && tx_s && !soft_rst) |=> (cur_act == $past(nxt_cur)));

   p_hold_while_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_s && !soft_rst) |=> ($stable(gain_act) && $stable(cur_act)));

   p_enable_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rise && !soft_rst) |=> (amp_en && cur_act == $past(nxt_cur)));

   p_soft_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (gain_act == '1 && cur_act == CUR_W'(CUR_DEF)));
endmodule

// File: tb/txen_settings_stage_bench.sv
`timescale 1ns/1ps
module txen_settings_stage_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic cs_n = 1'b1;
   logic tx_en_in = 1'b0;
   logic soft_rst = 1'b0;
   logic [5:0] gain_act;
   logic [1:0] cur_act;
   logic amp_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   txen_settings_stage u_txen_settings_stage (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cs_n(cs_n), .tx_en_in(tx_en_in), .soft_rst(soft_rst),
      .gain_act(gain_act), .cur_act(cur_act), .amp_en(amp_en));

   // {tx level, word (cur[7:6] gain[5:0]), expected gain, expected current}
   localparam logic [16:0] VEC [7] = '{
      {1'b1, 8'h8A, 6'd10, 2'd2},   // R1 R2 plain word
      {1'b1, 8'h03, 6'd5,  2'd0},   // R6 below floor
      {1'b1, 8'hC5, 6'd5,  2'd3},   // R6 at floor
      {1'b1, 8'h7F, 6'd63, 2'd1},   // R1 full gain
      {1'b0, 8'h20, 6'd63, 2'd1},   // R3 off: held
      {1'b1, 8'h41, 6'd5,  2'd1},   // R6 code 1
      {1'b1, 8'h00, 6'd5,  2'd0}    // R6 code 0
   };

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic frame(logic [7:0] w);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = w; end
      @(negedge clk) cfg_wr = 1'b0;
      @(negedge clk) cs_n = 1'b1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cycles(3);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R8 gain", gain_act, 63);
      chk("R8 cur", cur_act, 3);
      chk("R8 en", amp_en, 0);

      for (int i = 0; i < 7; i++) begin
         @(negedge clk) tx_en_in = VEC[i][16];
         cycles(5);
         frame(VEC[i][15:8]);
         cycles(2);
         chk($sformatf("R2/R3/R6 vec%0d gain", i), gain_act, VEC[i][7:2]);
         chk($sformatf("R1 vec%0d cur", i), cur_act, VEC[i][1:0]);
      end

      // R9 drop and R3 staged write while off
      @(negedge clk) tx_en_in = 1'b0;
      cycles(5);
      chk("R9 en low", amp_en, 0);
      frame(8'h96);
      cycles(2);
      chk("R3 gain held", gain_act, 5);
      chk("R3 cur held", cur_act, 0);

      // R4 / R9 reload timing
      @(negedge clk) tx_en_in = 1'b1;
      cycles(2);
      chk("R4 gain before", gain_act, 5);
      chk("R9 en before", amp_en, 0);
      cycles(1);
      chk("R4 gain after", gain_act, 22);
      chk("R4 cur after", cur_act, 2);
      chk("R9 en after", amp_en, 1);

      // R5 re-enable without new write
      @(negedge clk) tx_en_in = 1'b0;
      cycles(5);
      @(negedge clk) tx_en_in = 1'b1;
      cycles(5);
      chk("R5 gain", gain_act, 22);
      chk("R5 cur", cur_act, 2);

      // R11 write with cs still low
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = 8'hC8; end
      @(negedge clk) cfg_wr = 1'b0;
      cycles(3);
      chk("R11 gain", gain_act, 22);
      chk("R11 cur", cur_act, 2);
      @(negedge clk) cs_n = 1'b1;
      cycles(1);
      chk("R2 edge gain", gain_act, 8);
      chk("R2 edge cur", cur_act, 3);

      // R7 soft reset, then re-enable keeps defaults
      frame(8'h4C);
      cycles(2);
      @(negedge clk) soft_rst = 1'b1;
      @(negedge clk) soft_rst = 1'b0;
      #1;
      chk("R7 gain", gain_act, 63);
      chk("R7 cur", cur_act, 3);
      @(negedge clk) tx_en_in = 1'b0;
      cycles(5);
      @(negedge clk) tx_en_in = 1'b1;
      cycles(5);
      chk("R7 staged gain", gain_act, 63);
      chk("R7 staged cur", cur_act, 3);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule